// File: doc/BRIEF.md
# Effective Address and Address-Timing Unit

This unit forms a 16-bit memory operand address from a four-bit addressing-mode code. It uses the four pointer and index register values (BX, BP, SI, DI), a signed or unsigned 16-bit displacement and a separate absolute-address field. For register-based modes the address is a base register, an index register or a pair of them, plus the displacement. For the absolute mode it is the absolute field alone.

Next to the address the unit reports how many clocks the address computation costs, so that an execution-timing model can add it to an instruction's base cost. The cost depends on which registers are combined and on whether the displacement is zero. A mode code outside the defined set yields address zero and cost zero, and raises an invalid-mode flag. Segment arithmetic, the memory access itself and instruction decode belong to other blocks.

All three outputs are registered, one clock after the inputs are sampled. With the `PIPE` parameter at 0 the registers are removed and the outputs follow the inputs combinationally.

Top module: `ea_unit`

## Requirements
- R1: With PIPE=1, outputs change only on a rising clock edge and reflect the inputs sampled at that edge. Mode codes are 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX and 8 absolute.
- R2: In mode 8 the address equals the absolute-address input, whatever the displacement.
- R3: In modes 0 to 7 the address is the sum of the selected registers and the displacement, taken modulo 2^16.
- R4: Mode 8 costs 6 clocks, independent of the displacement.
- R5: The single-register modes 4 to 7 cost 5 clocks with a zero displacement.
- R6: With a zero displacement, modes 0 (BX+SI) and 3 (BP+DI) cost 7 clocks, and modes 1 (BX+DI) and 2 (BP+SI) cost 8 clocks.
- R7: In modes 0 to 7 a nonzero displacement adds 4 clocks to the cost.
- R8: Mode codes 9 to 15 give address 0, cost 0 and an invalid flag of 1. Every defined code gives an invalid flag of 0.
- R9: While reset is asserted, the address, the cost and the invalid flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Addressing-mode code |
| bx_i | input | AW | BX register value |
| bp_i | input | AW | BP register value |
| si_i | input | AW | SI register value |
| di_i | input | AW | DI register value |
| disp_i | input | AW | Displacement |
| abs_i | input | AW | Absolute-address field |
| addr_o | output | AW | Effective address |
| cycles_o | output | CW | Clock cost of the address computation |
| bad_mode_o | output | 1 | Invalid mode code |

## Verification
The hardest case to reach is a register-pair sum that wraps past 2^16 while the displacement is also nonzero, because an ordinary register set never overflows. The sweep therefore pairs every mode code with a register set whose values sit near the top of the range, and with displacements of 0, 1, all-ones and a mixed value. This covers both the wrap and the +4 cost step in every mode. The same sweep drives an absolute field that differs from every register sum, so an address taken from the wrong source cannot match.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [3:0] {
      EA_BX_SI = 4'd0,
      EA_BX_DI = 4'd1,
      EA_BP_SI = 4'd2,
      EA_BP_DI = 4'd3,
      EA_SI    = 4'd4,
      EA_DI    = 4'd5,
      EA_BP    = 4'd6,
      EA_BX    = 4'd7,
      EA_ABS   = 4'd8
   } ea_mode_e;

   // cost class of a mode
   typedef enum logic [1:0] {
      CLS_SINGLE    = 2'd0,
      CLS_PAIR_FAST = 2'd1,
      CLS_PAIR_SLOW = 2'd2,
      CLS_ABS       = 2'd3
   } ea_cls_e;

   typedef struct packed {
      logic    valid;
      logic    use_bx;
      logic    use_bp;
      logic    use_si;
      logic    use_di;
      ea_cls_e cls;
   } ea_sel_t;

   localparam int unsigned CYC_ABS       = 6;
   localparam int unsigned CYC_SINGLE    = 5;
   localparam int unsigned CYC_PAIR_FAST = 7;
   localparam int unsigned CYC_PAIR_SLOW = 8;
   localparam int unsigned CYC_DISP      = 4;
   localparam int unsigned CYC_MAX       = CYC_PAIR_SLOW + CYC_DISP;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
   import ea_pkg::*;
(
   input  logic [3:0] mode_i,
   output ea_sel_t    sel_o
);

   always_comb begin
      sel_o = '0;
      sel_o.valid = 1'b1;
      unique case (mode_i)
         EA_BX_SI: begin sel_o.use_bx = 1'b1; sel_o.use_si = 1'b1; sel_o.cls = CLS_PAIR_FAST; end
         EA_BX_DI: begin sel_o.use_bx = 1'b1; sel_o.use_di = 1'b1; sel_o.cls = CLS_PAIR_SLOW; end
         EA_BP_SI: begin sel_o.use_bp = 1'b1; sel_o.use_si = 1'b1; sel_o.cls = CLS_PAIR_SLOW; end
         EA_BP_DI: begin sel_o.use_bp = 1'b1; sel_o.use_di = 1'b1; sel_o.cls = CLS_PAIR_FAST; end
         EA_SI:    begin sel_o.use_si = 1'b1; sel_o.cls = CLS_SINGLE; end
         EA_DI:    begin sel_o.use_di = 1'b1; sel_o.cls = CLS_SINGLE; end
         EA_BP:    begin sel_o.use_bp = 1'b1; sel_o.cls = CLS_SINGLE; end
         EA_BX:    begin sel_o.use_bx = 1'b1; sel_o.cls = CLS_SINGLE; end
         EA_ABS:   begin sel_o.cls = CLS_ABS; end
         default:  begin sel_o.valid = 1'b0; end
      endcase
   end

endmodule

// File: rtl/ea_sum.sv
module ea_sum
   import ea_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  ea_sel_t       sel_i,
   input  logic [AW-1:0] bx_i,
   input  logic [AW-1:0] bp_i,
   input  logic [AW-1:0] si_i,
   input  logic [AW-1:0] di_i,
   input  logic [AW-1:0] disp_i,
   input  logic [AW-1:0] abs_i,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] base_v;
   logic [AW-1:0] index_v;
   logic [AW-1:0] reg_sum;

   // at most one base and one index register are selected
   always_comb begin
      base_v  = ({AW{sel_i.use_bx}} & bx_i) | ({AW{sel_i.use_bp}} & bp_i);
      index_v = ({AW{sel_i.use_si}} & si_i) | ({AW{sel_i.use_di}} & di_i);
      reg_sum = base_v + index_v + disp_i;   // wraps at AW bits
   end

   always_comb begin
      if (!sel_i.valid)            addr_o = '0;
      else if (sel_i.cls == CLS_ABS) addr_o = abs_i;
      else                         addr_o = reg_sum;
   end

endmodule

// File: rtl/ea_cost.sv
module ea_cost
   import ea_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned CW = 5
) (
   input  ea_sel_t       sel_i,
   input  logic [AW-1:0] disp_i,
   output logic [CW-1:0] cycles_o
);

   logic          disp_nz;
   logic [CW-1:0] base_cyc;

   assign disp_nz = |disp_i;

   always_comb begin
      unique case (sel_i.cls)
         CLS_SINGLE:    base_cyc = CW'(CYC_SINGLE);
         CLS_PAIR_FAST: base_cyc = CW'(CYC_PAIR_FAST);
         CLS_PAIR_SLOW: base_cyc = CW'(CYC_PAIR_SLOW);
         default:       base_cyc = CW'(CYC_ABS);
      endcase
   end

   always_comb begin
      if (!sel_i.valid)                         cycles_o = '0;
      else if (sel_i.cls == CLS_ABS)            cycles_o = base_cyc;
      else if (disp_nz)                         cycles_o = base_cyc + CW'(CYC_DISP);
      else                                      cycles_o = base_cyc;
   end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned CW   = 5,
   parameter bit          PIPE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    mode_i,
   input  logic [AW-1:0] bx_i,
   input  logic [AW-1:0] bp_i,
   input  logic [AW-1:0] si_i,
   input  logic [AW-1:0] di_i,
   input  logic [AW-1:0] disp_i,
   input  logic [AW-1:0] abs_i,
   output logic [AW-1:0] addr_o,
   output logic [CW-1:0] cycles_o,
   output logic          bad_mode_o
);

   localparam int unsigned CW_MIN = $clog2(CYC_MAX + 1);

   if (AW < 4) begin : g_chk_aw
      initial $error("ea_unit: AW must be at least 4");
   end
   if (CW < CW_MIN) begin : g_chk_cw
      initial $error("ea_unit: CW too narrow for the largest cost");
   end

   ea_sel_t       sel;
   logic [AW-1:0] addr_d;
   logic [CW-1:0] cyc_d;

   ea_mode_decode u_dec (
      .mode_i (mode_i),
      .sel_o  (sel)
   );

   ea_sum #(.AW(AW)) u_sum (
      .sel_i  (sel),
      .bx_i   (bx_i),
      .bp_i   (bp_i),
      .si_i   (si_i),
      .di_i   (di_i),
      .disp_i (disp_i),
      .abs_i  (abs_i),
      .addr_o (addr_d)
   );

   ea_cost #(.AW(AW), .CW(CW)) u_cost (
      .sel_i    (sel),
      .disp_i   (disp_i),
      .cycles_o (cyc_d)
   );

   if (PIPE) begin : g_reg
      logic primed;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_o     <= '0;
            cycles_o   <= '0;
            bad_mode_o <= 1'b0;
            primed     <= 1'b0;
         end else begin
            addr_o     <= addr_d;
            cycles_o   <= cyc_d;
            bad_mode_o <= ~sel.valid;
            primed     <= 1'b1;
         end
      end

      AST_ABS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && $past(rst_n) && $past(mode_i) == 4'd8) |-> addr_o == $past(abs_i)) else $error("abs addr"); // R2
      AST_ABS_COST: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && $past(rst_n) && $past(mode_i) == 4'd8) |-> cycles_o == CW'(CYC_ABS)) else $error("abs cost"); // R4
      AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         bad_mode_o |-> (addr_o == '0 && cycles_o == '0)) else $error("bad mode outputs"); // R8
      AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && $past(rst_n)) |-> bad_mode_o == ($past(mode_i) > 4'd8)) else $error("bad flag"); // R8
      AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         !bad_mode_o |-> (cycles_o == '0 || (cycles_o >= CW'(CYC_SINGLE) && cycles_o <= CW'(CYC_MAX)))) else $error("cost range"); // R7
      AST_RESET_CLEAR: assert property (@(posedge clk)
         $past(!rst_n) |-> (addr_o == '0 && cycles_o == '0 && !bad_mode_o)) else $error("reset"); // R9
   end else begin : g_comb
      assign addr_o     = addr_d;
      assign cycles_o   = cyc_d;
      assign bad_mode_o = ~sel.valid;
   end

endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;

   localparam int AW = 16;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    mode_i = '0;
   logic [AW-1:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0, disp_i = '0, abs_i = '0;
   logic [AW-1:0] addr_o;
   logic [CW-1:0] cycles_o;
   logic          bad_mode_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ea_unit #(.AW(AW), .CW(CW), .PIPE(1'b1)) i_ea_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .bx_i       (bx_i),
      .bp_i       (bp_i),
      .si_i       (si_i),
      .di_i       (di_i),
      .disp_i     (disp_i),
      .abs_i      (abs_i),
      .addr_o     (addr_o),
      .cycles_o   (cycles_o),
      .bad_mode_o (bad_mode_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (mode %0d disp %0h)", req, act, exp, mode_i, disp_i);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   function automatic logic [AW-1:0] ref_addr(input int m);
      logic [31:0] s;
      case (m)
         0: s = bx_i + si_i;
         1: s = bx_i + di_i;
         2: s = bp_i + si_i;
         3: s = bp_i + di_i;
         4: s = si_i;
         5: s = di_i;
         6: s = bp_i;
         7: s = bx_i;
         default: s = 0;
      endcase
      if (m == 8) return abs_i;
      if (m > 8) return '0;
      s = s + disp_i;
      return s[AW-1:0];
   endfunction

   function automatic int ref_cyc(input int m);
      int c;
      if (m > 8) return 0;
      if (m == 8) return 6;
      if (m >= 4) c = 5;
      else if (m == 0 || m == 3) c = 7;
      else c = 8;
      if (disp_i != 0) c += 4;
      return c;
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [AW-1:0] disps [4];
      logic [AW-1:0] prev;
      disps[0] = 16'h0000; disps[1] = 16'h0001; disps[2] = 16'hFFFF; disps[3] = 16'h1234;

      // R9: reset state
      mode_i = 4'd0; bx_i = 16'h1111; si_i = 16'h2222; disp_i = 16'h0005;
      repeat (3) @(negedge clk);
      chk("R9 addr", 32'(addr_o), 0);
      chk("R9 cycles", 32'(cycles_o), 0);
      chk("R9 flag", 32'(bad_mode_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int rs = 0; rs < 3; rs++) begin
         case (rs)
            0: begin bx_i = 16'h0100; bp_i = 16'h0200; si_i = 16'h0030; di_i = 16'h0004; abs_i = 16'hABCD; end
            1: begin bx_i = 16'hFFF0; bp_i = 16'h8001; si_i = 16'h0020; di_i = 16'hFFFF; abs_i = 16'h7777; end
            default: begin bx_i = 16'h5A5A; bp_i = 16'hC3C3; si_i = 16'h9009; di_i = 16'h0FF0; abs_i = 16'h0001; end
         endcase
         for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 16; m++) begin
               @(negedge clk);
               prev = addr_o;
               mode_i = 4'(m);
               disp_i = disps[d];
               #1;
               if (rs == 0 && d == 1 && m == 0) chk("R1 hold before edge", 32'(addr_o), 32'(prev));
               @(negedge clk);
               if (m == 8)      chk("R2 addr", 32'(addr_o), 32'(ref_addr(m)));
               else if (m > 8)  chk("R8 addr", 32'(addr_o), 32'(ref_addr(m)));
               else             chk("R3 addr", 32'(addr_o), 32'(ref_addr(m)));
               if (m == 8)                   chk("R4 cycles", 32'(cycles_o), 32'(ref_cyc(m)));
               else if (m > 8)               chk("R8 cycles", 32'(cycles_o), 32'(ref_cyc(m)));
               else if (disp_i != 0)         chk("R7 cycles", 32'(cycles_o), 32'(ref_cyc(m)));
               else if (m >= 4)              chk("R5 cycles", 32'(cycles_o), 32'(ref_cyc(m)));
               else                          chk("R6 cycles", 32'(cycles_o), 32'(ref_cyc(m)));
               chk("R8 flag", 32'(bad_mode_o), (m > 8) ? 1 : 0);
            end
         end
      end

      done = 1'b1;
      finish_run();
   end

endmodule